// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from six maskable sources and hands the processor one interrupt at a time. The sources are two external level inputs with a selectable trigger edge, two timer overflow pulses, a serial transfer-complete pulse and a multi-function group. The group merges four event pulses: a remote-timer overflow, a real-time-clock tick, a remote-input rising edge and a remote-input falling edge. Each request sets a pending flag. A flag counts as armed when its own enable bit and the global enable are both set.

The controller only takes a decision on a sampling strobe. Every request latched since the previous strobe is considered at once, and a fixed priority picks a single winner. If the return-address stack is not full, the controller produces a one-cycle acknowledge together with that source's vector address. Taking a source clears its flag and clears the global enable, so handlers do not nest unless software sets the global enable again. A return-with-enable strobe restores the global enable. A plain return strobe leaves it untouched. Software reaches flags, enables, sub-flags and edge modes through a small register port with a combinational read.

Top module: `irq_vector_ctl`

## Requirements
- R1: Among the armed flags, the one with the lowest flag bit index wins. Flag bits are 0 ext0, 1 ext1, 2 timer0, 3 timer1, 4 serial, 5 multi-function, and the vector is 0x04 + 4×index (ext0 0x04 up to multi 0x18). A pending flag whose enable bit is 0 is never acknowledged.
- R2: An acknowledge clears the winning flag and the global enable in the same clock edge. The control register at address 0 reads {0, enables[5:0] at bits 6:1, global enable at bit 0}.
- R3: While the global enable is 0, events still set their flags (register at address 1, bits 5:0), but no acknowledge is produced.
- R4: While stackFull is 1, a strobe produces no acknowledge even with an armed flag. The request is taken on a later strobe once stackFull is 0.
- R5: A retEnStb pulse sets the global enable. A retStb pulse leaves it unchanged. A write to address 0 sets or clears it, and an acknowledge in the same cycle takes precedence over both.
- R6: ackPulse is high for exactly the one cycle after the clock edge that samples sampleStb, and vecAddr is valid in that cycle. A strobe held for several cycles yields at most one acknowledge.
- R7: The edge register at address 3 holds the ext0 mode in bits 1:0 and the ext1 mode in bits 3:2. The codes are 00 falling edge only, 01 rising edge only, and 10 or 11 either edge. An edge that does not match the mode is ignored.
- R8: Any of the four group event pulses sets its sticky sub-flag (address 2, bit 0 overflow, 1 tick, 2 rising, 3 falling) and the group flag (bit 5). Servicing clears only the group flag. The sub-flags stay until software writes them.
- R9: A timer overflow pulse sets flag bit 2 or 3, and a serial transfer-complete pulse sets flag bit 4.
- R10: Writing address 1 sets or clears the flags bit by bit. A raw event in the same cycle as a write that clears its flag leaves the flag set.
- R11: After reset all flags, sub-flags, enables, edge modes and the global enable read 0, and ackPulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIn | input | 2 | External request levels |
| tmrOvf | input | 2 | Timer overflow pulses |
| serDone | input | 1 | Serial byte transfer complete pulse |
| mfEvt | input | 4 | Multi-function group event pulses |
| regAddr | input | 2 | Register address |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| stackFull | input | 1 | Return-address stack is full |
| sampleStb | input | 1 | Sampling strobe |
| retEnStb | input | 1 | Return that re-enables interrupts |
| retStb | input | 1 | Plain return |
| ackPulse | output | 1 | Acknowledge, one cycle |
| vecAddr | output | 8 | Vector address of the acknowledged source |

## Verification
On every cycle the assertions check the following:
- every acknowledge follows a strobe, with the global enable set and the stack not full;
- the acknowledge lasts one cycle, with a vector on the 4-byte grid and the global enable cleared;
- a serviced flag drops unless an event or a write overrides it, a raw event always leaves its flag set, and the group sub-flags survive service.

Only the bench scenarios can show the following:
- which source wins when several are pending, and that a disabled source is skipped;
- that each edge mode ignores the wrong edge;
- that a blocked request is served once the stack frees;
- that a plain return leaves interrupts disabled;
- that an event beats a same-cycle clearing write.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_EXT  = 2;
  localparam int NUM_TMR  = 2;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_SUB  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_EDGE = 2'd3;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edgeMode_t;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrFlag;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_SUB  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EXT-1:0]   extIn,
  input  logic [NUM_TMR-1:0]   tmrOvf,
  input  logic                 serDone,
  input  logic [N_SUB-1:0]     mfEvt,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic                 gie,
  input  ctlStrobe_t           strobes,
  output logic [NUM_SRC-1:0]   armed,
  output logic [DATA_W-1:0]    regRdata
);
  localparam int EDGE_W = 2 * NUM_EXT;

  logic [NUM_EXT-1:0] extPrev;
  logic [NUM_EXT-1:0] extHit;
  logic [EDGE_W-1:0]  edgeCfg;
  logic [NUM_SRC-1:0] srcEn;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] evt;
  logic [N_SUB-1:0]   subFlags;
  logic ctrlWr, flagWr, subWr, edgeWr;
  logic unusedWdata;

  assign ctrlWr = regWe && (regAddr == ADR_CTRL);
  assign flagWr = regWe && (regAddr == ADR_FLAG);
  assign subWr  = regWe && (regAddr == ADR_SUB);
  assign edgeWr = regWe && (regAddr == ADR_EDGE);
  assign unusedWdata = ^regWdata[DATA_W-1:NUM_SRC+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= '0;
      edgeCfg <= '0;
      srcEn   <= '0;
    end else begin
      extPrev <= extIn;
      if (edgeWr) edgeCfg <= regWdata[EDGE_W-1:0];
      if (ctrlWr) srcEn <= regWdata[NUM_SRC:1];
    end
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_edge
    logic riseSeen, fallSeen;
    edgeMode_t mode;
    assign riseSeen = extIn[e] && !extPrev[e];
    assign fallSeen = !extIn[e] && extPrev[e];
    assign mode = edgeMode_t'(edgeCfg[2*e +: 2]);
    always_comb begin
      unique case (mode)
        EDGE_FALL: extHit[e] = fallSeen;
        EDGE_RISE: extHit[e] = riseSeen;
        default:   extHit[e] = riseSeen || fallSeen;
      endcase
    end
  end

  assign evt = {|mfEvt, serDone, tmrOvf, extHit};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           flags[i] <= 1'b0;
      else if (evt[i])     flags[i] <= 1'b1;
      else if (flagWr)     flags[i] <= regWdata[i];
      else if (strobes.clrFlag[i]) flags[i] <= 1'b0;
    end

    // R2: a serviced flag drops when nothing else touches it
    p_flag_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clrFlag[i] && !evt[i] && !flagWr |=> !flags[i]);
    // R10: a raw event always leaves its flag set
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> flags[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) subFlags <= '0;
    else       subFlags <= mfEvt | (subWr ? regWdata[N_SUB-1:0] : subFlags);
  end

  // R8: servicing the group keeps every sticky sub-flag
  p_sub_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrFlag[NUM_SRC-1] && !subWr |=>
      ((subFlags & $past(subFlags)) == $past(subFlags)));

  assign armed = flags & srcEn;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADR_CTRL: regRdata[NUM_SRC:0]   = {srcEn, gie};
      ADR_FLAG: regRdata[NUM_SRC-1:0] = flags;
      ADR_SUB:  regRdata[N_SUB-1:0]   = subFlags;
      default:  regRdata[EDGE_W-1:0]  = edgeCfg;
    endcase
  end
endmodule

// File: rtl/irq_vec_control.sv
module irq_vec_control
  import irq_vec_pkg::*;
#(
  parameter int          VEC_W    = 8,
  parameter logic [7:0]  VEC_BASE = 8'h04,
  parameter int          VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] armed,
  input  logic               sampleStb,
  input  logic               stackFull,
  input  logic               retEnStb,
  input  logic               retStb,
  input  logic               gieWr,
  input  logic               gieWdata,
  output logic               gie,
  output ctlStrobe_t         strobes,
  output logic               ackPulse,
  output logic [VEC_W-1:0]   vecAddr
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int VEC_LAST = int'(VEC_BASE) + VEC_STEP * (NUM_SRC - 1);

  logic [IDX_W-1:0] winIdx;
  logic             take;

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (armed[i]) winIdx = IDX_W'(i);
    end
  end

  assign take = sampleStb && gie && !stackFull && (|armed);

  always_comb begin
    strobes = '0;
    if (take) strobes.clrFlag[winIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gie      <= 1'b0;
      ackPulse <= 1'b0;
      vecAddr  <= '0;
    end else begin
      ackPulse <= take;
      if (take) vecAddr <= VEC_W'(int'(VEC_BASE) + VEC_STEP * int'(winIdx));
      if (take)          gie <= 1'b0;
      else if (retEnStb) gie <= 1'b1;
      else if (gieWr)    gie <= gieWdata;
    end
  end

  // R1: vectors sit on the 4-byte grid inside the table
  p_vec_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (vecAddr[1:0] == 2'b00 && int'(vecAddr) >= int'(VEC_BASE)
                  && int'(vecAddr) <= VEC_LAST));
  // R2: taking an interrupt disables further ones
  p_ack_clears_gie_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !gie);
  // R3: no acknowledge without the global enable
  p_ack_needs_gie_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> $past(gie));
  // R4: a full stack blocks acknowledges
  p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !$past(stackFull));
  // R5: a plain return leaves the global enable alone
  p_ret_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    retStb && !retEnStb && !gieWr && !take |=> gie == $past(gie));
  // R6: one-cycle acknowledge that follows a strobe
  p_single_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> !ackPulse);
  p_strobe_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> $past(sampleStb));
  p_one_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.clrFlag));
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_SUB  = 4,
  parameter int VEC_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extIn,
  input  logic [NUM_TMR-1:0] tmrOvf,
  input  logic               serDone,
  input  logic [N_SUB-1:0]   mfEvt,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               stackFull,
  input  logic               sampleStb,
  input  logic               retEnStb,
  input  logic               retStb,
  output logic               ackPulse,
  output logic [VEC_W-1:0]   vecAddr
);
  logic               gie;
  ctlStrobe_t         strobes;
  logic [NUM_SRC-1:0] armed;
  logic               gieWr;

  assign gieWr = regWe && (regAddr == ADR_CTRL);

  irq_vec_datapath #(.DATA_W(DATA_W), .N_SUB(N_SUB)) i_dp (
    .clk(clk), .rstN(rstN), .extIn(extIn), .tmrOvf(tmrOvf),
    .serDone(serDone), .mfEvt(mfEvt), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .gie(gie), .strobes(strobes), .armed(armed),
    .regRdata(regRdata)
  );

  irq_vec_control #(.VEC_W(VEC_W)) i_ctl (
    .clk(clk), .rstN(rstN), .armed(armed), .sampleStb(sampleStb),
    .stackFull(stackFull), .retEnStb(retEnStb), .retStb(retStb),
    .gieWr(gieWr), .gieWdata(regWdata[0]), .gie(gie), .strobes(strobes),
    .ackPulse(ackPulse), .vecAddr(vecAddr)
  );
endmodule

// File: tb/test_irq_vector_ctl.sv
module test_irq_vector_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] extIn = '0;
  logic [1:0] tmrOvf = '0;
  logic serDone = 1'b0;
  logic [3:0] mfEvt = '0;
  logic [1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic stackFull = 1'b0, sampleStb = 1'b0, retEnStb = 1'b0, retStb = 1'b0;
  logic ackPulse;
  logic [7:0] vecAddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  irq_vector_ctl i_irq_vector_ctl (
    .clk(clk), .rstN(rstN), .extIn(extIn), .tmrOvf(tmrOvf), .serDone(serDone),
    .mfEvt(mfEvt), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .stackFull(stackFull), .sampleStb(sampleStb),
    .retEnStb(retEnStb), .retStb(retStb), .ackPulse(ackPulse), .vecAddr(vecAddr)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: every acknowledge must match the oldest expected vector
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && ackPulse) begin
        if (expQ.size() == 0) chk("R6 unexpected ack", vecAddr, 8'hFF);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk("R1 vector", vecAddr, e);
        end
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); regAddr = a; #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic strobe(int n);
    @(negedge clk); sampleStb = 1'b1;
    repeat (n) @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic settle(string tag);
    @(negedge clk);
    chk(tag, 8'(expQ.size()), 8'd0);
  endtask

  task automatic retEn();
    @(negedge clk); retEnStb = 1'b1;
    @(negedge clk); retEnStb = 1'b0;
  endtask

  task automatic setExt(int idx, logic v);
    @(negedge clk); extIn[idx] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    rd(2'd0, 8'h00, "R11 ctrl");
    rd(2'd1, 8'h00, "R11 flags");
    rd(2'd2, 8'h00, "R11 sub");
    rd(2'd3, 8'h00, "R11 edge");
    chk("R11 ack", {7'd0, ackPulse}, 8'h00);

    // R1/R2/R7/R9 mixed requests
    wr(2'd0, 8'h7F);
    setExt(1, 1'b1);
    rd(2'd1, 8'h00, "R7 rise ignored in falling mode");
    setExt(1, 1'b0);
    @(negedge clk); tmrOvf[0] = 1'b1; serDone = 1'b1;
    @(negedge clk); tmrOvf[0] = 1'b0; serDone = 1'b0;
    rd(2'd1, 8'h16, "R9 flags set");
    expQ.push_back(8'h08);
    strobe(1);
    settle("R1 ext1 taken");
    rd(2'd1, 8'h14, "R2 flag cleared");
    rd(2'd0, 8'h7E, "R2 gie cleared");

    // R3 gie off
    @(negedge clk); tmrOvf[1] = 1'b1;
    @(negedge clk); tmrOvf[1] = 1'b0;
    rd(2'd1, 8'h1C, "R3 flag still set");
    strobe(1);
    settle("R3 no ack");
    // R5 returns
    @(negedge clk); retStb = 1'b1;
    @(negedge clk); retStb = 1'b0;
    rd(2'd0, 8'h7E, "R5 plain return");
    retEn();
    rd(2'd0, 8'h7F, "R5 return with enable");

    // R4 stack full
    @(negedge clk); stackFull = 1'b1;
    strobe(1);
    settle("R4 blocked");
    rd(2'd1, 8'h1C, "R4 flags kept");
    @(negedge clk); stackFull = 1'b0;
    expQ.push_back(8'h0C);
    strobe(1);
    settle("R4 served later");
    rd(2'd1, 8'h18, "R4 flags after");

    // R1 per-source enable
    wr(2'd0, 8'h6F);
    expQ.push_back(8'h14);
    strobe(1);
    settle("R1 disabled source skipped");
    rd(2'd1, 8'h08, "R1 disabled flag kept");
    wr(2'd0, 8'h7F);
    expQ.push_back(8'h10);
    strobe(1);
    settle("R5 gie by write");
    rd(2'd1, 8'h00, "R2 all served");

    // R8 multi-function group
    wr(2'd0, 8'h7F);
    @(negedge clk); mfEvt = 4'b0100;
    @(negedge clk); mfEvt = 4'b0000;
    rd(2'd2, 8'h04, "R8 sub flag");
    rd(2'd1, 8'h20, "R8 group flag");
    expQ.push_back(8'h18);
    strobe(1);
    settle("R8 group taken");
    rd(2'd1, 8'h00, "R8 group cleared");
    rd(2'd2, 8'h04, "R8 sub sticky");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R8 sub cleared by write");
    @(negedge clk); mfEvt = 4'b1001;
    @(negedge clk); mfEvt = 4'b0000;
    rd(2'd2, 8'h09, "R8 two subs");
    rd(2'd1, 8'h20, "R8 group again");
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);

    // R7 edge modes
    wr(2'd3, 8'h01);
    setExt(0, 1'b1);
    rd(2'd1, 8'h01, "R7 rising mode");
    wr(2'd1, 8'h00);
    setExt(0, 1'b0);
    rd(2'd1, 8'h00, "R7 falling ignored in rising mode");
    wr(2'd3, 8'h02);
    setExt(0, 1'b1);
    rd(2'd1, 8'h01, "R7 both mode rise");
    wr(2'd1, 8'h00);
    setExt(0, 1'b0);
    rd(2'd1, 8'h01, "R7 both mode fall");
    wr(2'd1, 8'h00);
    rd(2'd3, 8'h02, "R7 edge register");

    // R10 software writes and collision
    @(negedge clk); regAddr = 2'd1; regWdata = 8'h00; regWe = 1'b1; tmrOvf[0] = 1'b1;
    @(negedge clk); regWe = 1'b0; tmrOvf[0] = 1'b0;
    rd(2'd1, 8'h04, "R10 event beats write");
    wr(2'd1, 8'h21);
    rd(2'd1, 8'h21, "R10 software set");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R10 software clear");

    // R1/R6 priority sweep, held strobe yields one ack
    wr(2'd1, 8'h3F);
    wr(2'd0, 8'h7F);
    for (int i = 0; i < 6; i++) begin
      expQ.push_back(8'(4 + 4 * i));
      strobe(2);
      settle("R6 one ack per strobe");
      retEn();
    end
    rd(2'd1, 8'h00, "R1 sweep drained");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule